// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Sequencer

This block sequences the per-frame work that precedes a display scan-out. When the controller is switched on, it checks the start and end addresses of one or two frame regions through an external address probe. It then waits for frame-start pulses. On each accepted pulse it reads a small palette header from the start of the active region, one 16-bit word per handshake. It copies every header word to an external palette RAM and keeps the depth code from word 0. From that code it derives the pixel depth and where the pixel data begins. It checks that the image fits inside the region and emits a single base-plus-length fetch request for the pixel data.

In dual mode, successive frames alternate between the two regions. A per-region condition flag and a DMA interrupt pulse mark each frame start. An image that does not fit its region latches a sync error and switches the controller off until software toggles the enable. Pixel conversion and display timing live elsewhere.

Top module: `fb_fetch_seq`

## Requirements
- R1: After reset, ctl_on, cur_valid, dma_cond, dma_irq, rd_valid, fetch_valid, pal_done and sync_err are all 0.
- R2: A rising edge on en_req probes, one per cycle with chk_req high, the addresses f1_top then f1_bot, and in dual mode also f2_top then f2_bot. If every probe returns chk_ok, ctl_on becomes 1 and the frame index is valid with cur_frame=0.
- R3: A probe answered with chk_ok=0 sets dma_cond[2], pulses dma_irq only when dma_ie[1]=1, and leaves ctl_on at 0 so that later frame_go pulses cause no reads and no fetch.
- R4: With pal_mode=1, frame_go is ignored: no read request and no fetch.
- R5: With pal_mode 0 or 3, a frame issues PAL_N read requests at base+2k for k=0..PAL_N-1. Each response is written out on the palette port with pal_waddr=k, and pal_done is set once the last word has arrived.
- R6: Bits 14:12 of header word 0 select the depth: 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=12 bpp, 5=16 bpp. Codes 4 and 5 occupy 2 bytes per pixel. Codes 0, 6 and 7 abort the frame with no fetch and no change to dma_cond.
- R7: fetch_addr is the region base plus a data offset: 2*SMALL_N for codes 1 and 2, 2*PAL_N for code 3, and 0 for codes 4 and 5. fetch_len is (w_m1+1)*(h_m1+1)*bpp/8 bytes.
- R8: If offset+fetch_len exceeds (bottom-top)+2 of the active region, sync_err is set, ctl_on drops and no fetch is issued. Equality is accepted.
- R9: Each issued fetch sets dma_cond[cur_frame] and pulses dma_irq when dma_ie[0]=1. In dual mode it toggles cur_frame, and the next frame uses the other region.
- R10: With sub_on=1, a fetch reports fetch_first=sub_line and fetch_lines=h_m1+1 when sub_first=1, and fetch_first=0 and fetch_lines=sub_line when sub_first=0. With sub_on=0 it reports fetch_first=0 and fetch_lines=h_m1+1.
- R11: A frame_go pulse that arrives while a frame is in progress is ignored.
- R12: A falling edge on en_req clears ctl_on, cur_valid, pal_done and sync_err.
- R13: With pal_mode=2, no header is read. The data offset is 0, and the depth comes from the most recently loaded header word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Controller enable level; edges start and stop it |
| dual_en | input | 1 | Alternate between two regions |
| pal_mode | input | 2 | 0/3 load header, 1 no fetch, 2 skip header |
| dma_ie | input | 2 | Bit 0 frame interrupt enable, bit 1 address-fault enable |
| w_m1 | input | DW | Image width minus one |
| h_m1 | input | DW | Image height minus one |
| sub_on | input | 1 | Sub-panel window active |
| sub_first | input | 1 | Sub-panel value is first line (1) or line count (0) |
| sub_line | input | DW | Sub-panel line value |
| f1_top | input | AW | Region 1 start address |
| f1_bot | input | AW | Region 1 end address |
| f2_top | input | AW | Region 2 start address |
| f2_bot | input | AW | Region 2 end address |
| frame_go | input | 1 | Frame-start pulse |
| chk_req | output | 1 | Address probe active |
| chk_addr | output | AW | Address being probed |
| chk_ok | input | 1 | Probe answer: address valid |
| rd_valid | output | 1 | Header read request valid |
| rd_addr | output | AW | Header read byte address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| pal_we | output | 1 | Palette RAM write strobe |
| pal_waddr | output | $clog2(PAL_N) | Palette RAM write index |
| pal_wdata | output | 16 | Palette RAM write data |
| fetch_valid | output | 1 | One-cycle pixel fetch request |
| fetch_addr | output | AW | Pixel data start address |
| fetch_len | output | AW | Pixel data byte count |
| fetch_first | output | DW | First displayed line |
| fetch_lines | output | DW+1 | Displayed line count |
| ctl_on | output | 1 | Controller running |
| cur_valid | output | 1 | Frame index valid |
| cur_frame | output | 1 | Current region index |
| dma_cond | output | 3 | Sticky flags: region 0 started, region 1 started, address fault |
| dma_irq | output | 1 | DMA interrupt pulse |
| pal_done | output | 1 | Header loaded |
| sync_err | output | 1 | Region overrun latched |

## Verification
The bench builds the sequencer with PAL_N=8, SMALL_N=2 and DW=6. With these values a header load is eight two-cycle reads, the two data offsets are 4 and 16 bytes, and images reach 64x64. That makes it cheap to sweep all eight depth codes across several geometries, including the largest one, and to compare every palette write word by word. The small sizes also allow the overrun comparison to be placed exactly at its limit and one byte beyond. Dual alternation, address-probe faults with and without the fault interrupt, the three header modes, the sub-panel cases and the busy-pulse case each get their own short scenario after a fresh reset.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PROBE,
    ST_IDLE,
    ST_PAL,
    ST_CHECK,
    ST_HALT
  } seq_st_t;

  // bytes-per-pixel scale applied to the pixel count
  typedef enum logic [1:0] {
    PX_QUARTER,
    PX_HALF,
    PX_ONE,
    PX_TWO
  } px_scale_t;

  localparam logic [1:0] PM_NOFETCH = 2'd1;
  localparam logic [1:0] PM_NOPAL   = 2'd2;

endpackage

// File: rtl/ffs_depth_dec.sv
module ffs_depth_dec
  import ffs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SMALL_OFF = 32,
  parameter int BIG_OFF   = 512
) (
  input  logic [2:0]    code,
  input  logic          hdr_used,
  output logic          dep_ok,
  output px_scale_t     scale,
  output logic [AW-1:0] data_off
);

  logic [AW-1:0] raw_off;

  always_comb begin
    dep_ok  = 1'b1;
    scale   = PX_ONE;
    raw_off = '0;
    case (code)
      3'd1: begin scale = PX_QUARTER; raw_off = AW'(SMALL_OFF); end
      3'd2: begin scale = PX_HALF;    raw_off = AW'(SMALL_OFF); end
      3'd3: begin scale = PX_ONE;     raw_off = AW'(BIG_OFF);   end
      3'd4, 3'd5: scale = PX_TWO;
      default: dep_ok = 1'b0;
    endcase
    data_off = hdr_used ? raw_off : '0;
  end

endmodule

// File: rtl/ffs_size_chk.sv
module ffs_size_chk
  import ffs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 10
) (
  input  logic [DW-1:0] w_m1,
  input  logic [DW-1:0] h_m1,
  input  px_scale_t     scale,
  input  logic [AW-1:0] data_off,
  input  logic [AW-1:0] reg_top,
  input  logic [AW-1:0] reg_bot,
  output logic [AW-1:0] byte_cnt,
  output logic          overrun
);

  localparam int PW = 2*DW + 2;
  localparam int BW = PW + 1;
  localparam int XW = AW + BW;

  logic [DW:0]   w_full, h_full;
  logic [PW-1:0] pix;
  logic [BW-1:0] bytes_full;
  logic [XW-1:0] need, limit;

  assign w_full = {1'b0, w_m1} + 1'b1;
  assign h_full = {1'b0, h_m1} + 1'b1;
  assign pix    = PW'(w_full) * PW'(h_full);

  always_comb begin
    case (scale)
      PX_QUARTER: bytes_full = BW'(pix >> 2);
      PX_HALF:    bytes_full = BW'(pix >> 1);
      PX_ONE:     bytes_full = BW'(pix);
      default:    bytes_full = BW'(pix) << 1;
    endcase
  end

  assign need     = XW'(data_off) + XW'(bytes_full);
  assign limit    = XW'(reg_bot - reg_top) + XW'(2);
  assign overrun  = need > limit;
  assign byte_cnt = AW'(bytes_full);

endmodule

// File: rtl/ffs_pal_reader.sv
module ffs_pal_reader #(
  parameter int AW    = 32,
  parameter int PAL_N = 256,
  localparam int IW   = $clog2(PAL_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic          pal_we,
  output logic [IW-1:0] pal_waddr,
  output logic [15:0]   pal_wdata,
  output logic [2:0]    first_code,
  output logic          done
);

  logic          busy, waiting;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;

  assign rd_valid = busy & ~waiting;
  assign rd_addr  = base_q + AW'({idx, 1'b0});

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy       <= 1'b0;
      waiting    <= 1'b0;
      idx        <= '0;
      pal_we     <= 1'b0;
      done       <= 1'b0;
      if (rst) begin
        base_q     <= '0;
        pal_waddr  <= '0;
        pal_wdata  <= '0;
        first_code <= '0;
      end
    end else begin
      pal_we <= 1'b0;
      done   <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        waiting <= 1'b0;
        idx     <= '0;
        base_q  <= base;
      end else if (busy && !waiting) begin
        if (rd_ready) waiting <= 1'b1;
      end else if (busy && rsp_valid) begin
        pal_we    <= 1'b1;
        pal_waddr <= idx;
        pal_wdata <= rsp_data;
        if (idx == '0) first_code <= rsp_data[14:12];
        if (idx == IW'(PAL_N-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx     <= idx + IW'(1);
          waiting <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
  import ffs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 10,
  parameter int PAL_N   = 256,
  parameter int SMALL_N = 16,
  localparam int IW     = $clog2(PAL_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dual_en,
  input  logic [1:0]    pal_mode,
  input  logic [1:0]    dma_ie,
  input  logic [DW-1:0] w_m1,
  input  logic [DW-1:0] h_m1,
  input  logic          sub_on,
  input  logic          sub_first,
  input  logic [DW-1:0] sub_line,
  input  logic [AW-1:0] f1_top,
  input  logic [AW-1:0] f1_bot,
  input  logic [AW-1:0] f2_top,
  input  logic [AW-1:0] f2_bot,
  input  logic          frame_go,
  output logic          chk_req,
  output logic [AW-1:0] chk_addr,
  input  logic          chk_ok,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic          pal_we,
  output logic [IW-1:0] pal_waddr,
  output logic [15:0]   pal_wdata,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] fetch_len,
  output logic [DW-1:0] fetch_first,
  output logic [DW:0]   fetch_lines,
  output logic          ctl_on,
  output logic          cur_valid,
  output logic          cur_frame,
  output logic [2:0]    dma_cond,
  output logic          dma_irq,
  output logic          pal_done,
  output logic          sync_err
);

  localparam int SMALL_OFF = 2*SMALL_N;
  localparam int BIG_OFF   = 2*PAL_N;

  seq_st_t       st;
  logic          en_q, en_rise, en_fall;
  logic [1:0]    vidx, last_v;
  logic [AW-1:0] base_q [2];
  logic          use_pal;
  logic          rdr_start, rdr_done;
  logic [2:0]    code;
  logic          dep_ok, overrun;
  px_scale_t     scale;
  logic [AW-1:0] data_off, byte_cnt;
  logic [AW-1:0] sel_top, sel_bot, sel_base;

  assign en_rise = en_req & ~en_q;
  assign en_fall = ~en_req & en_q;
  assign last_v  = dual_en ? 2'd3 : 2'd1;
  assign chk_req = (st == ST_PROBE);
  assign ctl_on  = (st == ST_IDLE) || (st == ST_PAL) || (st == ST_CHECK);

  always_comb begin
    case (vidx)
      2'd0:    chk_addr = f1_top;
      2'd1:    chk_addr = f1_bot;
      2'd2:    chk_addr = f2_top;
      default: chk_addr = f2_bot;
    endcase
  end

  assign sel_top  = cur_frame ? f2_top : f1_top;
  assign sel_bot  = cur_frame ? f2_bot : f1_bot;
  assign sel_base = base_q[cur_frame];

  assign rdr_start = (st == ST_IDLE) && frame_go && !en_fall && !en_rise &&
                     (pal_mode != PM_NOFETCH) && (pal_mode != PM_NOPAL);

  ffs_pal_reader #(.AW(AW), .PAL_N(PAL_N)) u_rdr (
    .clk(clk), .rst(rst), .abort(en_fall), .start(rdr_start), .base(sel_base),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .first_code(code), .done(rdr_done)
  );

  ffs_depth_dec #(.AW(AW), .SMALL_OFF(SMALL_OFF), .BIG_OFF(BIG_OFF)) u_dec (
    .code(code), .hdr_used(use_pal), .dep_ok(dep_ok), .scale(scale),
    .data_off(data_off)
  );

  ffs_size_chk #(.AW(AW), .DW(DW)) u_size (
    .w_m1(w_m1), .h_m1(h_m1), .scale(scale), .data_off(data_off),
    .reg_top(sel_top), .reg_bot(sel_bot), .byte_cnt(byte_cnt),
    .overrun(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_OFF;
      en_q        <= 1'b0;
      vidx        <= '0;
      cur_valid   <= 1'b0;
      cur_frame   <= 1'b0;
      base_q[0]   <= '0;
      base_q[1]   <= '0;
      use_pal     <= 1'b0;
      dma_cond    <= '0;
      dma_irq     <= 1'b0;
      pal_done    <= 1'b0;
      sync_err    <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
      fetch_len   <= '0;
      fetch_first <= '0;
      fetch_lines <= '0;
    end else begin
      en_q        <= en_req;
      dma_irq     <= 1'b0;
      fetch_valid <= 1'b0;
      if (en_fall) begin
        st        <= ST_OFF;
        cur_valid <= 1'b0;
        pal_done  <= 1'b0;
        sync_err  <= 1'b0;
      end else if (en_rise) begin
        st        <= ST_PROBE;
        vidx      <= '0;
        cur_valid <= 1'b1;
        cur_frame <= 1'b0;
      end else begin
        case (st)
          ST_PROBE: begin
            if (!chk_ok) begin
              dma_cond[2] <= 1'b1;
              dma_irq     <= dma_ie[1];
              st          <= ST_HALT;
            end else if (vidx == last_v) begin
              base_q[0] <= f1_top;
              base_q[1] <= f2_top;
              st        <= ST_IDLE;
            end else begin
              vidx <= vidx + 2'd1;
            end
          end
          ST_IDLE: begin
            if (frame_go && pal_mode == PM_NOPAL) begin
              use_pal <= 1'b0;
              st      <= ST_CHECK;
            end else if (frame_go && pal_mode != PM_NOFETCH) begin
              use_pal <= 1'b1;
              st      <= ST_PAL;
            end
          end
          ST_PAL: begin
            if (rdr_done) begin
              pal_done <= 1'b1;
              st       <= ST_CHECK;
            end
          end
          ST_CHECK: begin
            if (!dep_ok) begin
              st <= ST_IDLE;
            end else if (overrun) begin
              sync_err <= 1'b1;
              st       <= ST_HALT;
            end else begin
              fetch_valid <= 1'b1;
              fetch_addr  <= sel_base + data_off;
              fetch_len   <= byte_cnt;
              fetch_first <= (sub_on && sub_first) ? sub_line : '0;
              fetch_lines <= (sub_on && !sub_first) ? {1'b0, sub_line}
                                                    : {1'b0, h_m1} + 1'b1;
              dma_cond[cur_frame] <= 1'b1;
              dma_irq     <= dma_ie[0];
              if (dual_en) cur_frame <= ~cur_frame;
              st          <= ST_IDLE;
            end
          end
          default: st <= st;
        endcase
      end
    end
  end

endmodule

// File: rtl/ffs_chk.sv
module ffs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rsp_valid,
  input logic          pal_we,
  input logic          fetch_valid,
  input logic          ctl_on,
  input logic          cur_valid,
  input logic          sync_err,
  input logic [2:0]    dma_cond
);

  // R5: a stalled request keeps its address
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R5: palette writes only follow a response
  a_r5_we_after_rsp: assert property (@(posedge clk) disable iff (rst)
    pal_we |-> $past(rsp_valid));

  // R7: fetches come only from a running controller
  a_r7_fetch_running: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> $past(ctl_on));

  // R9: a fetch request is a single-cycle pulse
  a_r9_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  // R8: overrun stops the controller without a fetch
  a_r8_err_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_err) |-> !ctl_on && !fetch_valid);

  // R3: an address fault leaves the controller stopped
  a_r3_fault_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_cond[2]) |-> !ctl_on);

  // R12: no running controller without a valid frame index
  a_r12_idx_valid: assert property (@(posedge clk) disable iff (rst)
    !cur_valid |-> !ctl_on);

  // R4: header reads and fetches never overlap
  a_r4_one_activity: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, fetch_valid}));

endmodule

bind fb_fetch_seq ffs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .rsp_valid(rsp_valid), .pal_we(pal_we),
  .fetch_valid(fetch_valid), .ctl_on(ctl_on), .cur_valid(cur_valid),
  .sync_err(sync_err), .dma_cond(dma_cond)
);

// File: tb/sim_fb_fetch_seq.sv
module sim_fb_fetch_seq;

  localparam int AW = 32;
  localparam int DW = 6;
  localparam int PN = 8;
  localparam int SN = 2;
  localparam int IW = $clog2(PN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          en_req = 0, dual_en = 0, sub_on = 0, sub_first = 0, frame_go = 0;
  logic [1:0]    pal_mode = 0, dma_ie = 0;
  logic [DW-1:0] w_m1 = 0, h_m1 = 0, sub_line = 0;
  logic [AW-1:0] f1_top = 32'h1000, f1_bot = 32'h9000;
  logic [AW-1:0] f2_top = 32'h20000, f2_bot = 32'h28000;
  logic          chk_req, chk_ok, rd_valid, rsp_valid = 0, pal_we, fetch_valid;
  logic [AW-1:0] chk_addr, rd_addr, fetch_addr, fetch_len;
  logic          rd_ready = 1'b1;
  logic [15:0]   rsp_data = 0, pal_wdata;
  logic [IW-1:0] pal_waddr;
  logic [DW-1:0] fetch_first;
  logic [DW:0]   fetch_lines;
  logic          ctl_on, cur_valid, cur_frame, dma_irq, pal_done, sync_err;
  logic [2:0]    dma_cond;

  logic [AW-1:0] bad_addr = 32'hFFFF_FFFF;
  logic [15:0]   hdr = 0;
  assign chk_ok = (chk_addr != bad_addr);

  fb_fetch_seq #(.AW(AW), .DW(DW), .PAL_N(PN), .SMALL_N(SN)) u0 (.*);

  int total = 0, errs = 0;
  int rd_cnt = 0, pw_cnt = 0, f_cnt = 0, irq_cnt = 0, chk_n = 0;
  logic [AW-1:0] f_addr, f_len, pbase = 0;
  logic [DW-1:0] f_first;
  logic [DW:0]   f_lines;
  logic [AW-1:0] chk_seq [4];
  logic          pend = 0;
  logic [AW-1:0] paddr = 0;

  function automatic logic [15:0] mem(input logic [AW-1:0] a);
    return (a == f1_top || a == f2_top) ? hdr : (a[15:0] ^ 16'h5A5A);
  endfunction

  function automatic longint exp_bytes(input int code, input int w, input int h);
    case (code)
      1: return (w*h)/4;
      2: return (w*h)/2;
      3: return w*h;
      4, 5: return w*h*2;
      default: return 0;
    endcase
  endfunction

  function automatic longint exp_off(input int code);
    if (code == 1 || code == 2) return 2*SN;
    if (code == 3) return 2*PN;
    return 0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory responder and output monitors, sampled at the falling edge
  initial forever begin
    @(negedge clk);
    rsp_valid = 1'b0;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_data  = mem(paddr);
      pend      = 1'b0;
    end
    if (rd_valid) begin
      pend  = 1'b1;
      paddr = rd_addr;
      chk("R5 read address", rd_addr, pbase + 2*rd_cnt);
      rd_cnt++;
    end
    if (pal_we) begin
      chk("R5 palette index", pal_waddr, pw_cnt);
      chk("R5 palette data", pal_wdata, mem(pbase + 2*pw_cnt));
      pw_cnt++;
    end
    if (fetch_valid) begin
      f_cnt++;
      f_addr = fetch_addr; f_len = fetch_len;
      f_first = fetch_first; f_lines = fetch_lines;
    end
    if (dma_irq) irq_cnt++;
    if (chk_req && chk_n < 4) begin
      chk_seq[chk_n] = chk_addr;
      chk_n++;
    end
  end

  task automatic clr_counts();
    rd_cnt = 0; pw_cnt = 0; f_cnt = 0; irq_cnt = 0; chk_n = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en_req = 0; dual_en = 0; pal_mode = 0; dma_ie = 0; sub_on = 0;
    frame_go = 0; bad_addr = 32'hFFFF_FFFF;
    f1_bot = 32'h9000; f2_bot = 32'h28000;
    repeat (3) @(negedge clk);
    rst = 0;
    clr_counts();
  endtask

  task automatic enable();
    @(negedge clk); en_req = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [AW-1:0] b);
    pbase = b;
    clr_counts();
    @(negedge clk); frame_go = 1;
    @(negedge clk); frame_go = 0;
    repeat (3*PN + 12) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic exp_c0;
    do_reset();
    // R1 reset state
    chk("R1 ctl_on", ctl_on, 0);
    chk("R1 cur_valid", cur_valid, 0);
    chk("R1 dma_cond", dma_cond, 0);
    chk("R1 dma_irq", dma_irq, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 fetch_valid", fetch_valid, 0);
    chk("R1 pal_done", pal_done, 0);
    chk("R1 sync_err", sync_err, 0);

    // R2 single-region probe and start
    enable();
    chk("R2 probe count", chk_n, 2);
    chk("R2 probe 0", chk_seq[0], f1_top);
    chk("R2 probe 1", chk_seq[1], f1_bot);
    chk("R2 ctl_on", ctl_on, 1);
    chk("R2 cur_valid", cur_valid, 1);
    chk("R2 cur_frame", cur_frame, 0);

    // R6 R7 R5 R9 sweep of depth codes and sizes
    dma_ie = 2'b01;
    exp_c0 = 0;
    for (int code = 0; code < 8; code++) begin
      for (int s = 0; s < 3; s++) begin
        int w, h, ok;
        w = (s == 0) ? 4 : (s == 1) ? 8 : 64;
        h = (s == 0) ? 4 : (s == 1) ? 3 : 64;
        w_m1 = DW'(w - 1); h_m1 = DW'(h - 1);
        hdr = 16'(code << 12) | 16'h0A5;
        frame(f1_top);
        ok = (code >= 1 && code <= 5) ? 1 : 0;
        if (ok) exp_c0 = 1;
        chk("R5 read count", rd_cnt, PN);
        chk("R5 pal_done", pal_done, 1);
        chk("R6 fetch issued", f_cnt, ok);
        chk("R9 irq count", irq_cnt, ok);
        chk("R9 cond bit 0", dma_cond[0], exp_c0);
        chk("R6 cond bit 1 untouched", dma_cond[1], 0);
        if (ok) begin
          chk("R7 fetch address", f_addr, f1_top + exp_off(code));
          chk("R7 fetch length", f_len, exp_bytes(code, w, h));
          chk("R10 full lines", f_lines, h);
          chk("R10 first 0", f_first, 0);
        end
      end
    end

    // R13 skip-header mode reuses last code (code 1 loaded now)
    w_m1 = 7; h_m1 = 7; hdr = 16'h1000;
    frame(f1_top);
    pal_mode = 2'd2;
    frame(f1_top);
    chk("R13 no reads", rd_cnt, 0);
    chk("R13 fetch issued", f_cnt, 1);
    chk("R13 zero offset", f_addr, f1_top);
    chk("R13 length from code 1", f_len, 16);

    // R4 no-fetch mode
    pal_mode = 2'd1;
    frame(f1_top);
    chk("R4 no reads", rd_cnt, 0);
    chk("R4 no fetch", f_cnt, 0);
    pal_mode = 2'd0;

    // R11 second pulse while busy
    hdr = 16'h3000;
    pbase = f1_top; clr_counts();
    @(negedge clk); frame_go = 1; @(negedge clk); frame_go = 0;
    repeat (4) @(negedge clk); frame_go = 1; @(negedge clk); frame_go = 0;
    repeat (3*PN + 12) @(negedge clk);
    chk("R11 single fetch", f_cnt, 1);
    chk("R11 single load", rd_cnt, PN);

    // R10 sub-panel
    sub_on = 1; sub_first = 1; sub_line = 5;
    frame(f1_top);
    chk("R10 first line", f_first, 5);
    chk("R10 lines full", f_lines, 8);
    sub_first = 0;
    frame(f1_top);
    chk("R10 first zero", f_first, 0);
    chk("R10 lines limited", f_lines, 5);
    sub_on = 0;

    // R8 overrun boundary: code 3, 4x4 -> 16 + 16 = 32 bytes
    w_m1 = 3; h_m1 = 3; hdr = 16'h3000;
    f1_bot = f1_top + 30;
    frame(f1_top);
    chk("R8 exact fit fetch", f_cnt, 1);
    chk("R8 no error", sync_err, 0);
    f1_bot = f1_top + 29;
    frame(f1_top);
    chk("R8 overrun no fetch", f_cnt, 0);
    chk("R8 sync_err", sync_err, 1);
    chk("R8 ctl_on low", ctl_on, 0);

    // R12 disable clears status
    @(negedge clk); en_req = 0;
    repeat (3) @(negedge clk);
    chk("R12 sync_err", sync_err, 0);
    chk("R12 pal_done", pal_done, 0);
    chk("R12 cur_valid", cur_valid, 0);
    chk("R12 ctl_on", ctl_on, 0);

    // R2 R9 dual alternation
    do_reset();
    dual_en = 1; dma_ie = 2'b01; w_m1 = 3; h_m1 = 3; hdr = 16'h3000;
    enable();
    chk("R2 dual probe count", chk_n, 4);
    chk("R2 dual probe 2", chk_seq[2], f2_top);
    chk("R2 dual probe 3", chk_seq[3], f2_bot);
    frame(f1_top);
    chk("R9 first region", f_addr, f1_top + 2*PN);
    chk("R9 toggled to 1", cur_frame, 1);
    frame(f2_top);
    chk("R9 second region", f_addr, f2_top + 2*PN);
    chk("R9 toggled to 0", cur_frame, 0);
    chk("R9 both cond bits", dma_cond, 3'b011);

    // R3 probe fault with and without its interrupt
    for (int ie = 0; ie < 2; ie++) begin
      do_reset();
      dual_en = 1; dma_ie = ie ? 2'b10 : 2'b00; bad_addr = f2_bot;
      enable();
      chk("R3 fault cond", dma_cond, 3'b100);
      chk("R3 fault irq", irq_cnt, ie);
      chk("R3 stopped", ctl_on, 0);
      frame(f1_top);
      chk("R3 no reads", rd_cnt, 0);
      chk("R3 no fetch", f_cnt, 0);
    end

    finish_up();
  end

endmodule